// File: doc/BRIEF.md
# Two-Channel Bus Switch Control Slave

This block is the digital core of a two-way downstream bus switch. It acts as a slave on a two-wire serial bus and holds one 8-bit control byte. The two low bits of that byte drive the enable lines of two downstream channels. An external switch model uses those enables to connect or isolate each channel's clock and data pair.

The system clock oversamples the bus lines. Each line passes through a two-flop synchronizer before START, STOP and clock edges are detected. The slave pulls the data line low only through an open-drain enable. Two strap pins and a prefix-select strap set its 7-bit address.

A host writes the control byte to choose channels. The choice reaches the outputs only at the next STOP, so a channel is never connected in the middle of a transfer. A read returns the live state of two interrupt levels in place of the upper bits, so the host can find out which channel raised an interrupt. An active-low reset clears everything and deselects both channels.

Top module: `i2csw_top`

## Requirements
- R1: The slave answers only the 7-bit address made of a 5-bit prefix followed by strap bits {addr_strap[1], addr_strap[0]}. The prefix is 11100 when alt_prefix is 0 and 11110 when alt_prefix is 1. The slave acknowledges a matching address by pulling SDA low in the ninth clock. For any other address it gives no acknowledge and stays off the bus until the next START or STOP.
- R2: The eighth bit after START sets the direction: 1 selects a read and 0 selects a write.
- R3: In a write, every data byte after the address is acknowledged. Only the last complete byte is kept.
- R4: Control bit 0 enables channel 0 (chan_en[0]) and bit 1 enables channel 1 (chan_en[1]). Both may be set together.
- R5: A written channel selection reaches chan_en only when the next STOP is detected. chan_en does not change at the data acknowledge or at a repeated START.
- R6: A read returns the following byte:
  - bits 7:6 are 0;
  - bit 5 is 1 when irq_n[1] is low, and bit 4 is 1 when irq_n[0] is low, whatever was written to those bits;
  - bits 3:2 are the last written bits 3:2;
  - bits 1:0 are the channel enables currently applied.
- R7: While rst_n is low, and after it is released, the control byte, the channel enables and the bus state machine are all zero. chan_en is 0 and SDA is released.
- R8: During a read, a master acknowledge (SDA low in the ninth clock) makes the slave send the byte again. A master not-acknowledge makes the slave release SDA and wait for START or STOP.
- R9: A repeated START restarts address reception without a STOP in between.
- R10: The slave changes its SDA drive only after SCL falls, or when it releases SDA at START or STOP. It never changes SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock that oversamples the bus |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | serial clock line level |
| sda_in | input | 1 | serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_strap | input | 2 | low two address bits |
| alt_prefix | input | 1 | 0 selects prefix 11100, 1 selects prefix 11110 |
| irq_n | input | NCH | filtered active-low interrupt levels, one per channel |
| chan_en | output | NCH | applied downstream channel enables |

## Verification
The address test covers all eight strap and prefix settings. For each setting it offers all sixteen addresses 0x70 to 0x7F and expects exactly one acknowledge. This tells a correct prefix-and-strap compare apart from one that ignores a strap bit or the prefix select. Each rejected address is followed by a data byte, which shows whether a rejected slave stays silent.

Sixteen two-byte writes then cover every value of bits 3:0. The upper bits of each kept byte are filled with a varying pattern, and the discarded first byte is the complement of the kept one. This separates keeping the last byte from keeping the first, and separates returning the interrupt levels from echoing written bits. Each write is followed by a read under a different interrupt pattern.

Separate sequences check three timing behaviours:
- a write followed by a repeated START and a read, which tells STOP-time commit apart from commit at the acknowledge;
- a multi-byte read ended by a not-acknowledge;
- a reset in the middle of a write.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } sw_state_e;
endpackage

// File: rtl/i2csw_sync.sv
module i2csw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic rst_sync_n,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;  // index 0 = clock line, 1 = data line

  logic [1:0]       rst_pipe;
  logic [LINES-1:0] pin_raw;
  logic [LINES-1:0] pin_s;
  logic [LINES-1:0] pin_p;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign pin_raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) chain <= '1;
      else             chain <= {chain[STAGES-2:0], pin_raw[g]};
    end
    assign pin_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pin_p <= '1;
    else             pin_p <= pin_s;
  end

  assign sda_s     = pin_s[1];
  assign scl_rise  = pin_s[0] & ~pin_p[0];
  assign scl_fall  = ~pin_s[0] & pin_p[0];
  assign start_evt = pin_s[0] & pin_p[0] & pin_p[1] & ~pin_s[1];
  assign stop_evt  = pin_s[0] & pin_p[0] & ~pin_p[1] & pin_s[1];
endmodule

// File: rtl/i2csw_fsm.sv
module i2csw_fsm
  import i2csw_pkg::*;
#(
  parameter int           PFX_W    = 5,
  parameter int           STRAP_W  = 2,
  parameter logic [4:0]   PREFIX_A = 5'b11100,
  parameter logic [4:0]   PREFIX_B = 5'b11110,
  parameter int           WR_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               alt_sel,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_byte,
  output logic               sda_oe,
  output logic               wr_stb,
  output logic [WR_W-1:0]    wr_bits
);
  localparam int ADDR_W = PFX_W + STRAP_W;

  sw_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              rw_q, rw_d;
  logic              ack_q, ack_d;
  logic [ADDR_W-1:0] my_addr;
  logic              addr_hit;

  assign my_addr  = {(alt_sel ? PREFIX_B[PFX_W-1:0] : PREFIX_A[PFX_W-1:0]), strap};
  assign addr_hit = (sh_q[BYTE_W-1:BYTE_W-ADDR_W] == my_addr);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    oe_d   = oe_q;
    rw_d   = rw_q;
    ack_d  = ack_q;
    wr_stb = 1'b0;
    if (start_evt) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop_evt) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (st_q == ST_ADDR) begin
              if (addr_hit) begin
                st_d = ST_AACK;
                oe_d = 1'b1;
                rw_d = sh_q[0];
              end else begin
                st_d = ST_SKIP;
              end
            end else begin
              st_d   = ST_WACK;
              oe_d   = 1'b1;
              wr_stb = 1'b1;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              st_d = ST_RDAT;
              sh_d = rd_byte;
              oe_d = ~rd_byte[BYTE_W-1];
            end else begin
              st_d = ST_WDAT;
              oe_d = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            st_d  = ST_WDAT;
            cnt_d = '0;
            oe_d  = 1'b0;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              st_d = ST_RACK;
              oe_d = 1'b0;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_d = ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              st_d  = ST_RDAT;
              cnt_d = '0;
              sh_d  = rd_byte;
              oe_d  = ~rd_byte[BYTE_W-1];
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
      rw_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      oe_q  <= oe_d;
      rw_q  <= rw_d;
      ack_q <= ack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_bits = sh_q[WR_W-1:0];

  AST_OE_MOVES_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall || start_evt || stop_evt)); // R10
  AST_WRITE_BYTE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> oe_q); // R3
  AST_SKIP_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> !oe_q); // R1
endmodule

// File: rtl/i2csw_ctrl.sv
module i2csw_ctrl
  import i2csw_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [2*NCH-1:0]     wr_bits,
  input  logic                 stop_evt,
  input  logic [NCH-1:0]       irq_n,
  output logic [NCH-1:0]       chan_en,
  output logic [BYTE_W-1:0]    rd_byte
);
  localparam int IRQ_LSB = 2 * NCH;

  logic [NCH-1:0] pend_q, pend_d;
  logic [NCH-1:0] keep_q, keep_d;
  logic [NCH-1:0] chan_q, chan_d;

  always_comb begin
    pend_d = pend_q;
    keep_d = keep_q;
    chan_d = chan_q;
    if (wr_stb) begin
      pend_d = wr_bits[NCH-1:0];
      keep_d = wr_bits[IRQ_LSB-1:NCH];
    end
    if (stop_evt) chan_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      keep_q <= '0;
      chan_q <= '0;
    end else begin
      pend_q <= pend_d;
      keep_q <= keep_d;
      chan_q <= chan_d;
    end
  end

  always_comb begin
    rd_byte                        = '0;
    rd_byte[NCH-1:0]               = chan_q;
    rd_byte[IRQ_LSB-1:NCH]         = keep_q;
    rd_byte[IRQ_LSB+NCH-1:IRQ_LSB] = ~irq_n;
  end

  assign chan_en = chan_q;

  AST_EN_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_q) |-> $past(stop_evt)); // R5
endmodule

// File: rtl/i2csw_top.sv
module i2csw_top
  import i2csw_pkg::*;
#(
  parameter int         NCH         = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] PREFIX_A    = 5'b11100,
  parameter logic [4:0] PREFIX_B    = 5'b11110
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_in,
  input  logic           sda_in,
  output logic           sda_oe,
  input  logic [1:0]     addr_strap,
  input  logic           alt_prefix,
  input  logic [NCH-1:0] irq_n,
  output logic [NCH-1:0] chan_en
);
  localparam int WR_W = 2 * NCH;

  logic              rst_sync_n;
  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_stb;
  logic [WR_W-1:0]   wr_bits;
  logic [BYTE_W-1:0] rd_byte;

  i2csw_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .arst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .rst_sync_n(rst_sync_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2csw_fsm #(
    .PFX_W(5), .STRAP_W(2), .PREFIX_A(PREFIX_A), .PREFIX_B(PREFIX_B), .WR_W(WR_W)
  ) i_fsm (
    .clk(clk), .rst_n(rst_sync_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .alt_sel(alt_prefix), .strap(addr_strap), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_bits(wr_bits)
  );

  i2csw_ctrl #(.NCH(NCH)) i_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb), .wr_bits(wr_bits),
    .stop_evt(stop_evt), .irq_n(irq_n), .chan_en(chan_en), .rd_byte(rd_byte)
  );
endmodule

// File: tb/test_i2csw_top.sv
module test_i2csw_top;
  localparam int QW = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_oe;
  logic [1:0] strap;
  logic       alt;
  logic [1:0] irq_n;
  logic [1:0] chan_en;
  logic       sda_bus;

  int n_chk = 0;
  int n_fail = 0;
  int hold_viol = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2csw_top i_i2csw_top (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .addr_strap(strap), .alt_prefix(alt), .irq_n(irq_n), .chan_en(chan_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (QW) @(negedge clk);
  endtask

  task automatic bit_tx(input logic b, output logic rb);
    logic oe_a;
    sda_m = b; qwait;
    scl_m = 1'b1; qwait;
    rb = sda_bus; oe_a = sda_oe; qwait;
    if (sda_oe !== oe_a) hold_viol++;
    scl_m = 1'b0; qwait;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; qwait;
    scl_m = 1'b1; qwait;
    sda_m = 1'b0; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qwait;
    scl_m = 1'b1; qwait;
    sda_m = 1'b1; qwait;
  endtask

  task automatic byte_wr(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_tx(v[i], r);
    bit_tx(1'b1, r);
    ack = ~r;
  endtask

  task automatic byte_rd(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_tx(1'b1, r);
      v[i] = r;
    end
    bit_tx(~mack, r);
  endtask

  function automatic logic [6:0] dev_addr(input logic a, input logic [1:0] s);
    return {(a ? 5'b11110 : 5'b11100), s};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic       ack, r;
    logic [7:0] rv, wb, expb;
    logic [1:0] exp_chan, p;
    logic [6:0] me;

    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    strap = 2'd0; alt = 1'b0; irq_n = 2'b11;
    repeat (5) @(negedge clk);
    chk("R7 chan_en in reset", chan_en, 2'b00);
    chk("R7 sda_oe in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 address sweep over all strap/prefix settings
    for (int a = 0; a < 2; a++) begin
      for (int s = 0; s < 4; s++) begin
        alt = a[0]; strap = s[1:0];
        for (int lo = 0; lo < 16; lo++) begin
          logic [6:0] cand;
          cand = 7'h70 + 7'(lo);
          bus_start;
          byte_wr({cand, 1'b0}, ack);
          chk($sformatf("R1 ack addr %0h alt %0d strap %0d", cand, a, s),
              ack, (cand == dev_addr(a[0], s[1:0])));
          if (!ack) begin
            byte_wr(8'h03, ack);
            chk("R1 ignored after mismatch", ack, 1'b0);
          end
          bus_stop;
          chk("R1 chan_en unchanged", chan_en, 2'b00);
        end
      end
    end

    alt = 1'b1; strap = 2'd2;
    me = dev_addr(1'b1, 2'd2);
    exp_chan = 2'b00;

    // R3 R4 R5 R6 R2 write/read sweep
    for (int v = 0; v < 16; v++) begin
      wb = {v[0], v[2], v[1], v[3], v[3:0]};
      bus_start;
      byte_wr({me, 1'b0}, ack);
      chk("R2 write address acked", ack, 1'b1);
      byte_wr(~wb, ack);
      chk("R3 first data byte acked", ack, 1'b1);
      byte_wr(wb, ack);
      chk("R3 last data byte acked", ack, 1'b1);
      chk("R5 chan_en held before stop", chan_en, exp_chan);
      bus_stop;
      repeat (4) @(negedge clk);
      exp_chan = wb[1:0];
      chk("R4 chan_en after stop", chan_en, exp_chan);
      p = 2'(v * 3);
      irq_n = ~p;
      bus_start;
      byte_wr({me, 1'b1}, ack);
      chk("R2 read address acked", ack, 1'b1);
      byte_rd(1'b0, rv);
      bus_stop;
      expb = {2'b00, p, wb[3:2], wb[1:0]};
      chk("R6 read byte", rv, expb);
    end

    // R8 multi-byte read, ended by not-acknowledge
    irq_n = 2'b10;
    expb = {2'b00, 2'b01, wb[3:2], exp_chan};
    bus_start;
    byte_wr({me, 1'b1}, ack);
    byte_rd(1'b1, rv);
    chk("R8 byte 1", rv, expb);
    byte_rd(1'b1, rv);
    chk("R8 byte 2 after ack", rv, expb);
    byte_rd(1'b0, rv);
    chk("R8 byte 3", rv, expb);
    chk("R8 sda released after nack", sda_oe, 1'b0);
    bit_tx(1'b1, r);
    chk("R8 no drive after nack", r, 1'b1);
    bus_stop;

    // R9 repeated start: write then read without stop
    irq_n = 2'b11;
    bus_start;
    byte_wr({me, 1'b0}, ack);
    byte_wr(8'h06, ack);
    bus_start;
    byte_wr({me, 1'b1}, ack);
    chk("R9 address acked after repeated start", ack, 1'b1);
    byte_rd(1'b0, rv);
    chk("R9 read before stop keeps old enables", rv, {6'b000001, exp_chan});
    chk("R5 chan_en unchanged at repeated start", chan_en, exp_chan);
    bus_stop;
    repeat (4) @(negedge clk);
    chk("R5 chan_en after stop", chan_en, 2'b10);

    // R7 reset in the middle of a write
    bus_start;
    byte_wr({me, 1'b0}, ack);
    byte_wr(8'h0F, ack);
    bus_stop;
    repeat (4) @(negedge clk);
    chk("R4 both channels enabled", chan_en, 2'b11);
    bus_start;
    byte_wr({me, 1'b0}, ack);
    sda_m = 1'b0; qwait;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 chan_en cleared by reset", chan_en, 2'b00);
    chk("R7 sda released by reset", sda_oe, 1'b0);
    scl_m = 1'b1; sda_m = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    irq_n = 2'b01;
    bus_start;
    byte_wr({me, 1'b1}, ack);
    byte_rd(1'b0, rv);
    bus_stop;
    chk("R7 register cleared after reset", rv, 8'b0010_0000);

    chk("R10 sda steady while scl high", hold_viol, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule